// File: doc/BRIEF.md
# Super I/O Configuration Register Block

This block is the configuration front end of a legacy multi-function I/O controller. A host reaches it through a two-byte window on a byte-wide bus. The even address is a pointer port that selects one of the internal registers. The odd address is the data port that reads or writes the selected register. Three 8-bit registers are held: a function-enable register, a function-address register and a power/test register. The 5-bit strap input picks their contents at reset from a fixed 32-entry table.

Reads of the pointer port right after reset return a two-byte identification sequence. After that they return the current pointer. A write to the pointer port ends the sequence early. From the three registers the block continuously decodes, for one parallel port, two serial ports, a floppy controller and an IDE channel, an enable flag, an I/O base address and an interrupt number. The chip-level glue uses these to place the peripherals on the bus.

The decoded outputs are registered. A data-port write lands in the register on one clock edge, and the decoded outputs follow on the next edge.

Top module: `sio_cfg_unit`

## Requirements
- R1: `bus_addr`=0 selects the pointer port and `bus_addr`=1 the data port. A data access with pointer 0, 1 or 2 reads or writes the enable, address or power/test register. Read data is valid while `bus_rd` is high.
- R2: A data write while the pointer is 3 or above changes no register. A data read in that state returns 0x00.
- R3: After reset the first pointer-port read returns 0x88, the second returns 0x00, and later ones return the pointer. A read counts once, when its strobe drops, however many cycles it is held.
- R4: Any pointer-port write ends the identification sequence at once. The next pointer-port read returns the written value.
- R5: Reset sets the pointer to 0 and loads the registers from the strap-indexed table. Strap 1 gives enable 0x4F, address 0x11, power/test 0x00. Strap 31 gives 0x00, 0x10, 0x02.
- R6: Enable register bits: bit0 parallel, bit1 serial 0, bit2 serial 1, bit3 floppy, bit5 floppy alternate address, bit6 IDE, bit7 IDE alternate address.
- R7: Address register bits [1:0] place the parallel port. 0 gives 0x378, with IRQ 7 if power/test bit3 is set and IRQ 5 otherwise. 1 gives 0x3BC with IRQ 7. 2 gives 0x278 with IRQ 5. 3 leaves the port unplaced and `par_en` low.
- R8: Serial port n uses selector field address[2n+3:2n+2]. Selector 0 gives 0x3F8 and selector 1 gives 0x2F8. For selectors 2 and 3, address bits [7:6] (group 0..3) choose the base. Even selectors take 0x3E8, 0x338, 0x2E8, 0x220. Odd selectors take 0x2E8, 0x238, 0x2E0, 0x228.
- R9: A serial port's IRQ is 3 when its selector is odd and 4 when it is even.
- R10: The floppy base is 0x370 when its alternate bit is set and 0x3F0 otherwise, with IRQ 6. The IDE base is 0x170 when its alternate bit is set and 0x1F0 otherwise. Its secondary base is the primary plus 0x206, with IRQ 14.
- R11: The decoded outputs change on the clock edge after the edge that writes a register, not on the writing edge.
- R12: A function that is not enabled drives its enable, base-address and IRQ outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap | input | 5 | Reset-table select, sampled during reset |
| bus_addr | input | 1 | 0 = pointer port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| par_en | output | 1 | Parallel port placed and enabled |
| par_base | output | 16 | Parallel port base address |
| par_irq | output | 4 | Parallel port IRQ |
| uart_en | output | 2 | Serial port enables, bit n = port n |
| uart_base | output | 32 | Serial bases, [15:0] port 0, [31:16] port 1 |
| uart_irq | output | 8 | Serial IRQs, [3:0] port 0, [7:4] port 1 |
| fdc_en | output | 1 | Floppy controller enable |
| fdc_base | output | 16 | Floppy controller base |
| fdc_irq | output | 4 | Floppy controller IRQ |
| ide_en | output | 1 | IDE channel enable |
| ide_base | output | 16 | IDE primary base |
| ide_base2 | output | 16 | IDE secondary base |
| ide_irq | output | 4 | IDE IRQ |

## Verification
The decode is driven with every address-register group under both the even and the odd upper selector on each serial port. Crossing the two ports this way shows whether each port reads its own field and whether the odd and even base tables are swapped. The parallel field is stepped through all four values with the power/test bit both set and clear, so the IRQ override is seen to act only for selector 0. The two strap extremes and the floppy/IDE alternate bits show that the reset table and the single-bit placements reach the outputs. Pointer-port reads with short and stretched strobes, with and without an earlier pointer write, separate the identification steps from plain pointer readback.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam int BYTE_W   = 8;
    localparam int STRAP_W  = 5;
    localparam int IO_W     = 16;
    localparam int IRQ_W    = 4;
    localparam int NUM_UART = 2;
    localparam int NUM_CFG  = 3;
    localparam int SEL_W    = $clog2(NUM_CFG);

    // enable register bit positions
    localparam int EN_PAR     = 0;
    localparam int EN_UART0   = 1;
    localparam int EN_FDC     = 3;
    localparam int EN_FDC_ALT = 5;
    localparam int EN_IDE     = 6;
    localparam int EN_IDE_ALT = 7;
    // power/test bit that moves the parallel IRQ for selector 0
    localparam int PW_PAR_HI  = 3;

    localparam logic [BYTE_W-1:0] ID_FIRST  = 8'h88;
    localparam logic [BYTE_W-1:0] ID_SECOND = 8'h00;

    typedef logic [IO_W-1:0]  io_addr_t;
    typedef logic [IRQ_W-1:0] irq_t;

    typedef struct packed {
        logic                               par_en;
        io_addr_t                           par_base;
        irq_t                               par_irq;
        logic [NUM_UART-1:0]                uart_en;
        logic [NUM_UART-1:0][IO_W-1:0]      uart_base;
        logic [NUM_UART-1:0][IRQ_W-1:0]     uart_irq;
        logic                               fdc_en;
        io_addr_t                           fdc_base;
        irq_t                               fdc_irq;
        logic                               ide_en;
        io_addr_t                           ide_base;
        io_addr_t                           ide_base2;
        irq_t                               ide_irq;
    } io_map_t;

    // strap-indexed reset contents of the enable register
    function automatic logic [BYTE_W-1:0] boot_en(input logic [STRAP_W-1:0] s);
        logic [BYTE_W-1:0] v;
        case (s) inside
            [5'd0:5'd5]:   v = 8'h4F;
            [5'd6:5'd11]:  v = 8'h4B;
            [5'd12:5'd15]: v = 8'h0F;
            [5'd16:5'd19]: v = 8'h49;
            [5'd20:5'd23]: v = 8'h07;
            [5'd24:5'd29]: v = 8'h47;
            5'd30:         v = 8'h08;
            default:       v = 8'h00;
        endcase
        return v;
    endfunction

    // strap-indexed reset contents of the address register
    function automatic logic [BYTE_W-1:0] boot_addr(input logic [STRAP_W-1:0] s);
        logic [BYTE_W-1:0] v;
        case (s)
            5'd0, 5'd12, 5'd20, 5'd24, 5'd30, 5'd31: v = 8'h10;
            5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26:  v = 8'h11;
            5'd3, 5'd14, 5'd22, 5'd27:               v = 8'h39;
            5'd4, 5'd15, 5'd23, 5'd28:               v = 8'h24;
            5'd5, 5'd29:                             v = 8'h38;
            5'd6, 5'd16, 5'd19:                      v = 8'h00;
            5'd7, 5'd8, 5'd17, 5'd18:                v = 8'h01;
            5'd9:                                    v = 8'h09;
            default:                                 v = 8'h08;
        endcase
        return v;
    endfunction

    // strap-indexed reset contents of the power/test register
    function automatic logic [BYTE_W-1:0] boot_pw(input logic [STRAP_W-1:0] s);
        return (s == 5'd31) ? 8'h02 : 8'h00;
    endfunction

    // base for serial selectors 2/3: odd flag and group from address[7:6]
    function automatic io_addr_t uart_upper_base(input logic odd, input logic [1:0] grp);
        io_addr_t b;
        case ({odd, grp})
            3'b000:  b = io_addr_t'('h3E8);
            3'b001:  b = io_addr_t'('h338);
            3'b010:  b = io_addr_t'('h2E8);
            3'b011:  b = io_addr_t'('h220);
            3'b100:  b = io_addr_t'('h2E8);
            3'b101:  b = io_addr_t'('h238);
            3'b110:  b = io_addr_t'('h2E0);
            default: b = io_addr_t'('h228);
        endcase
        return b;
    endfunction

    function automatic io_map_t decode_map(input logic [BYTE_W-1:0] en_r,
                                           input logic [BYTE_W-1:0] addr_r,
                                           input logic              par_hi);
        io_map_t   m;
        logic [1:0] psel;
        logic [1:0] usel;
        m    = '0;
        psel = addr_r[1:0];
        if (en_r[EN_PAR] && (psel != 2'd3)) begin
            m.par_en = 1'b1;
            case (psel)
                2'd0: begin
                    m.par_base = io_addr_t'('h378);
                    m.par_irq  = par_hi ? irq_t'(7) : irq_t'(5);
                end
                2'd1: begin
                    m.par_base = io_addr_t'('h3BC);
                    m.par_irq  = irq_t'(7);
                end
                default: begin
                    m.par_base = io_addr_t'('h278);
                    m.par_irq  = irq_t'(5);
                end
            endcase
        end
        for (int i = 0; i < NUM_UART; i++) begin
            usel = addr_r[2*i+2 +: 2];
            if (en_r[EN_UART0+i]) begin
                m.uart_en[i] = 1'b1;
                case (usel)
                    2'd0:    m.uart_base[i] = io_addr_t'('h3F8);
                    2'd1:    m.uart_base[i] = io_addr_t'('h2F8);
                    default: m.uart_base[i] = uart_upper_base(usel[0], addr_r[7:6]);
                endcase
                m.uart_irq[i] = usel[0] ? irq_t'(3) : irq_t'(4);
            end
        end
        if (en_r[EN_FDC]) begin
            m.fdc_en   = 1'b1;
            m.fdc_base = en_r[EN_FDC_ALT] ? io_addr_t'('h370) : io_addr_t'('h3F0);
            m.fdc_irq  = irq_t'(6);
        end
        if (en_r[EN_IDE]) begin
            m.ide_en    = 1'b1;
            m.ide_base  = en_r[EN_IDE_ALT] ? io_addr_t'('h170) : io_addr_t'('h1F0);
            m.ide_base2 = m.ide_base + io_addr_t'('h206);
            m.ide_irq   = irq_t'(14);
        end
        return m;
    endfunction

endpackage

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
    import sio_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STRAP_W-1:0]  strap,
    input  logic                bus_addr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    input  logic                bus_wr,
    input  logic                bus_rd,
    output logic [BYTE_W-1:0]   bus_rdata,
    output logic [BYTE_W-1:0]   cfg_en,
    output logic [BYTE_W-1:0]   cfg_addr,
    output logic [BYTE_W-1:0]   cfg_pw
);

    localparam logic [BYTE_W-1:0] CFG_LIMIT = BYTE_W'(NUM_CFG);
    localparam logic [1:0]        ID_DONE   = 2'd2;

    typedef struct packed {
        logic [BYTE_W-1:0]              ptr;
        logic [1:0]                     id_step;
        logic                           ptr_rd_prev;
        logic [NUM_CFG-1:0][BYTE_W-1:0] cfg;
    } acc_state_t;

    acc_state_t s_d, s_q, s_boot;
    logic       ptr_rd;
    logic       ptr_ok;

    assign ptr_rd = bus_rd && !bus_addr;
    assign ptr_ok = s_q.ptr < CFG_LIMIT;

    always_comb begin
        s_boot             = '0;
        s_boot.cfg[0]      = boot_en(strap);
        s_boot.cfg[1]      = boot_addr(strap);
        s_boot.cfg[2]      = boot_pw(strap);
    end

    always_comb begin
        s_d             = s_q;
        s_d.ptr_rd_prev = ptr_rd;
        // identification step moves on when a pointer-port read ends
        if (s_q.ptr_rd_prev && !ptr_rd && (s_q.id_step != ID_DONE)) begin
            s_d.id_step = s_q.id_step + 2'd1;
        end
        if (bus_wr && !bus_addr) begin
            s_d.ptr     = bus_wdata;
            s_d.id_step = ID_DONE;
        end
        if (bus_wr && bus_addr && ptr_ok) begin
            s_d.cfg[s_q.ptr[SEL_W-1:0]] = bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= s_boot;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (!bus_addr) begin
                case (s_q.id_step)
                    2'd0:    bus_rdata = ID_FIRST;
                    2'd1:    bus_rdata = ID_SECOND;
                    default: bus_rdata = s_q.ptr;
                endcase
            end else if (ptr_ok) begin
                bus_rdata = s_q.cfg[s_q.ptr[SEL_W-1:0]];
            end
        end
    end

    assign cfg_en   = s_q.cfg[0];
    assign cfg_addr = s_q.cfg[1];
    assign cfg_pw   = s_q.cfg[2];

    // R2: writes through an out-of-range pointer leave every register alone
    assert_rsv_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && !ptr_ok) |=> $stable(s_q.cfg));

    // R4: once the pointer has been written, pointer reads return it
    assert_ptr_write_ends_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr) |=> ((bus_rd && !bus_addr) ? (bus_rdata == $past(bus_wdata)) : 1'b1));

    // R2: an out-of-range data read yields zero
    assert_rsv_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr && (s_q.ptr >= CFG_LIMIT)) |-> (bus_rdata == '0));

endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
    import sio_cfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STRAP_W-1:0]  strap,
    input  logic [BYTE_W-1:0]   en_r,
    input  logic [BYTE_W-1:0]   addr_r,
    input  logic [BYTE_W-1:0]   pw_r,
    output io_map_t             map_o
);

    io_map_t map_d, map_q, map_boot;
    logic    unused_cfg_bits;

    assign unused_cfg_bits = ^{en_r[4], pw_r[BYTE_W-1:PW_PAR_HI+1], pw_r[PW_PAR_HI-1:0]};

    always_comb begin
        map_d    = decode_map(en_r, addr_r, pw_r[PW_PAR_HI]);
        map_boot = decode_map(boot_en(strap), boot_addr(strap), boot_pw(strap)[PW_PAR_HI]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= map_boot;
        end else begin
            map_q <= map_d;
        end
    end

    assign map_o = map_q;

    // R11: decoded outputs only move one edge after a register change
    assert_decode_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(en_r) && $stable(addr_r) && $stable(pw_r)) |=> $stable(map_q));

    // R12: an unplaced parallel port drives no base and no IRQ
    assert_par_off_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !map_q.par_en |-> ((map_q.par_base == '0) && (map_q.par_irq == '0)));

    // R10: IDE secondary block sits a fixed distance above the primary
    assert_ide_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        map_q.ide_en |-> ((map_q.ide_base2 == map_q.ide_base + io_addr_t'('h206))
                          && (map_q.ide_irq == irq_t'(14))));

endmodule

// File: rtl/sio_cfg_unit.sv
module sio_cfg_unit
    import sio_cfg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [STRAP_W-1:0]         strap,
    input  logic                       bus_addr,
    input  logic [BYTE_W-1:0]          bus_wdata,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    output logic [BYTE_W-1:0]          bus_rdata,
    output logic                       par_en,
    output logic [IO_W-1:0]            par_base,
    output logic [IRQ_W-1:0]           par_irq,
    output logic [NUM_UART-1:0]        uart_en,
    output logic [NUM_UART*IO_W-1:0]   uart_base,
    output logic [NUM_UART*IRQ_W-1:0]  uart_irq,
    output logic                       fdc_en,
    output logic [IO_W-1:0]            fdc_base,
    output logic [IRQ_W-1:0]           fdc_irq,
    output logic                       ide_en,
    output logic [IO_W-1:0]            ide_base,
    output logic [IO_W-1:0]            ide_base2,
    output logic [IRQ_W-1:0]           ide_irq
);

    logic [BYTE_W-1:0] cfg_en, cfg_addr, cfg_pw;
    io_map_t           map;

    sio_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap     (strap),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .cfg_en    (cfg_en),
        .cfg_addr  (cfg_addr),
        .cfg_pw    (cfg_pw)
    );

    sio_cfg_decode u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .strap  (strap),
        .en_r   (cfg_en),
        .addr_r (cfg_addr),
        .pw_r   (cfg_pw),
        .map_o  (map)
    );

    assign par_en    = map.par_en;
    assign par_base  = map.par_base;
    assign par_irq   = map.par_irq;
    assign uart_en   = map.uart_en;
    assign uart_base = map.uart_base;
    assign uart_irq  = map.uart_irq;
    assign fdc_en    = map.fdc_en;
    assign fdc_base  = map.fdc_base;
    assign fdc_irq   = map.fdc_irq;
    assign ide_en    = map.ide_en;
    assign ide_base  = map.ide_base;
    assign ide_base2 = map.ide_base2;
    assign ide_irq   = map.ide_irq;

endmodule

// File: tb/sio_cfg_unit_tb.sv
module sio_cfg_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap = 5'd1;
    logic        bus_addr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        par_en, fdc_en, ide_en;
    logic [15:0] par_base, fdc_base, ide_base, ide_base2;
    logic [3:0]  par_irq, fdc_irq, ide_irq;
    logic [1:0]  uart_en;
    logic [31:0] uart_base;
    logic [7:0]  uart_irq;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    sio_cfg_unit u_dut (
        .clk(clk), .rst_n(rst_n), .strap(strap),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata),
        .par_en(par_en), .par_base(par_base), .par_irq(par_irq),
        .uart_en(uart_en), .uart_base(uart_base), .uart_irq(uart_irq),
        .fdc_en(fdc_en), .fdc_base(fdc_base), .fdc_irq(fdc_irq),
        .ide_en(ide_en), .ide_base(ide_base), .ide_base2(ide_base2), .ide_irq(ide_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [4:0] s);
        @(negedge clk);
        rst_n = 1'b0;
        strap = s;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, input int hold, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #5 v = bus_rdata;
        for (int k = 1; k < hold; k++) begin
            @(negedge clk);
            #5 if (bus_rdata !== v) v = 8'hEE;
        end
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_reg(input logic [7:0] idx, input logic [7:0] val);
        bus_write(1'b0, idx);
        bus_write(1'b1, val);
        @(negedge clk);
    endtask

    task automatic get_reg(input logic [7:0] idx, output logic [7:0] v);
        bus_write(1'b0, idx);
        bus_read(1'b1, 1, v);
    endtask

    task automatic t_reset_strap1;
        logic [7:0] v;
        do_reset(5'd1);
        chk("R5 par_en", par_en, 1);
        chk("R7 par_base", par_base, 'h3BC);
        chk("R7 par_irq", par_irq, 7);
        chk("R6 uart_en", uart_en, 2'b11);
        chk("R8 uart0 base", uart_base[15:0], 'h3F8);
        chk("R8 uart1 base", uart_base[31:16], 'h2F8);
        chk("R9 uart0 irq", uart_irq[3:0], 4);
        chk("R9 uart1 irq", uart_irq[7:4], 3);
        chk("R10 fdc", {fdc_en, fdc_base, fdc_irq}, {1'b1, 16'h3F0, 4'd6});
        chk("R10 ide", {ide_en, ide_base, ide_base2, ide_irq}, {1'b1, 16'h1F0, 16'h3F6, 4'd14});
        bus_read(1'b0, 1, v); chk("R3 id first", v, 'h88);
        bus_read(1'b0, 1, v); chk("R3 id second", v, 'h00);
        bus_read(1'b0, 1, v); chk("R3 pointer after id", v, 'h00);
        bus_read(1'b1, 1, v); chk("R5 en reg strap1", v, 'h4F);
        get_reg(8'd1, v);     chk("R1 addr reg strap1", v, 'h11);
        get_reg(8'd2, v);     chk("R1 pw reg strap1", v, 'h00);
    endtask

    task automatic t_reset_strap31;
        logic [7:0] v;
        do_reset(5'd31);
        chk("R12 all off strap31", {par_en, uart_en, fdc_en, ide_en}, 0);
        chk("R12 zero bases", {par_base, uart_base, fdc_base, ide_base, ide_base2}, 0);
        chk("R12 zero irqs", {par_irq, uart_irq, fdc_irq, ide_irq}, 0);
        bus_read(1'b0, 3, v); chk("R3 stretched first read", v, 'h88);
        bus_read(1'b0, 1, v); chk("R3 second after stretched", v, 'h00);
        bus_read(1'b1, 1, v); chk("R5 en reg strap31", v, 'h00);
        get_reg(8'd1, v);     chk("R5 addr reg strap31", v, 'h10);
        get_reg(8'd2, v);     chk("R5 pw reg strap31", v, 'h02);
    endtask

    task automatic t_ptr_write_ends_id;
        logic [7:0] v;
        do_reset(5'd1);
        bus_write(1'b0, 8'd2);
        bus_read(1'b0, 1, v); chk("R4 pointer read after write", v, 'h02);
    endtask

    task automatic t_reserved_index;
        logic [7:0] v;
        do_reset(5'd1);
        bus_write(1'b0, 8'd5);
        bus_write(1'b1, 8'hAA);
        bus_read(1'b1, 1, v); chk("R2 reserved read", v, 'h00);
        bus_read(1'b0, 1, v); chk("R1 pointer readback 5", v, 'h05);
        get_reg(8'd0, v); chk("R2 en unchanged", v, 'h4F);
        get_reg(8'd1, v); chk("R2 addr unchanged", v, 'h11);
        get_reg(8'd2, v); chk("R2 pw unchanged", v, 'h00);
        chk("R2 decode unchanged", par_base, 'h3BC);
    endtask

    task automatic t_parallel;
        do_reset(5'd1);
        set_reg(8'd1, 8'h00);
        set_reg(8'd2, 8'h08);
        chk("R7 sel0 hi", {par_en, par_base, par_irq}, {1'b1, 16'h378, 4'd7});
        set_reg(8'd2, 8'h00);
        chk("R7 sel0 lo", {par_en, par_base, par_irq}, {1'b1, 16'h378, 4'd5});
        set_reg(8'd1, 8'h01);
        chk("R7 sel1", {par_en, par_base, par_irq}, {1'b1, 16'h3BC, 4'd7});
        set_reg(8'd2, 8'h08);
        set_reg(8'd1, 8'h02);
        chk("R7 sel2", {par_en, par_base, par_irq}, {1'b1, 16'h278, 4'd5});
        set_reg(8'd1, 8'h03);
        chk("R7 sel3 none", {par_en, par_base, par_irq}, 0);
    endtask

    task automatic t_uart;
        logic [15:0] even_t [4];
        logic [15:0] odd_t [4];
        even_t = '{16'h3E8, 16'h338, 16'h2E8, 16'h220};
        odd_t  = '{16'h2E8, 16'h238, 16'h2E0, 16'h228};
        do_reset(5'd1);
        set_reg(8'd0, 8'h06);
        chk("R6 only uarts", {par_en, uart_en, fdc_en, ide_en}, 5'b01100);
        chk("R12 par off zero", {par_base, par_irq}, 0);
        chk("R12 fdc off zero", {fdc_base, fdc_irq}, 0);
        for (int g = 0; g < 4; g++) begin
            set_reg(8'd1, 8'((g << 6) | 8'h38));
            chk("R8 u0 sel2", uart_base[15:0], even_t[g]);
            chk("R8 u1 sel3", uart_base[31:16], odd_t[g]);
            chk("R9 irq sel2/sel3", uart_irq, {4'd3, 4'd4});
            set_reg(8'd1, 8'((g << 6) | 8'h2C));
            chk("R8 u0 sel3", uart_base[15:0], odd_t[g]);
            chk("R8 u1 sel2", uart_base[31:16], even_t[g]);
            chk("R9 irq sel3/sel2", uart_irq, {4'd4, 4'd3});
        end
        set_reg(8'd0, 8'h04);
        chk("R12 uart0 off", {uart_en[0], uart_base[15:0], uart_irq[3:0]}, 0);
        chk("R6 uart1 alone", uart_en, 2'b10);
    endtask

    task automatic t_fdc_ide;
        do_reset(5'd1);
        set_reg(8'd0, 8'hE8);
        chk("R10 fdc alt", {fdc_en, fdc_base, fdc_irq}, {1'b1, 16'h370, 4'd6});
        chk("R10 ide alt", {ide_en, ide_base, ide_base2, ide_irq}, {1'b1, 16'h170, 16'h376, 4'd14});
        set_reg(8'd0, 8'h48);
        chk("R10 fdc main", fdc_base, 'h3F0);
        chk("R10 ide main", {ide_base, ide_base2}, {16'h1F0, 16'h3F6});
        set_reg(8'd0, 8'h01);
        chk("R12 ide off", {ide_en, ide_base, ide_base2, ide_irq}, 0);
    endtask

    task automatic t_latency;
        do_reset(5'd1);
        bus_write(1'b0, 8'd0);
        bus_write(1'b1, 8'h00);
        chk("R11 old value one edge after write", ide_en, 1);
        @(negedge clk);
        chk("R11 new value second edge", ide_en, 0);
    endtask

    initial begin
        t_reset_strap1;
        t_reset_strap31;
        t_ptr_write_ends_id;
        t_reserved_index;
        t_parallel;
        t_uart;
        t_fdc_ide;
        t_latency;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule